// File: doc/BRIEF.md
# Address Window Bus Bridge

This bridge connects an upstream memory-mapped port with a 32-bit address to a downstream port with a 33-bit address. The upstream address space holds a 4096-byte forwarded window. At the upstream address just past the window, address 4096, sits one local base register. An upstream access inside the window goes downstream in the same cycle. Its downstream address is the base register plus the upstream address, so software can reach any part of the larger space by first moving the base.

Both ports use the same signal set: address, read strobe, write strobe, address-ready, byte enables, write data, read data and a read-data-valid strobe. Requests pass through combinationally, with no buffering. The bridge serves base-register reads and reads above the register address locally. It holds back such local reads while forwarded reads are still outstanding, so that read data always returns upstream in request order. A counter of outstanding forwarded reads has a parameterised limit and stalls new forwarded reads once that limit is reached.

Top module: `addr_window_bridge`

## Requirements
- R1: After reset the base register is 0, `up_rvalid` is low, and no forwarded read is counted as outstanding.
- R2: An upstream access with address below 4096 is forwarded in the same cycle. `dn_rd`/`dn_wr` follow `up_rd`/`up_wr`, `dn_be` and `dn_wdata` are passed unchanged, and `up_ardy` equals `dn_ardy`.
- R3: A write to address 4096 is accepted at once (`up_ardy` high) and issues no downstream request. Byte lane i of the base register (bits 8i+7..8i) takes `up_wdata` in that lane only when `up_be[i]` is 1. The new value applies to requests presented from the next cycle.
- R4: A read of address 4096 issues no downstream request. `up_rvalid` is high with `up_rdata` equal to the base register value exactly one cycle after the read is accepted.
- R5: Accesses above 4096 issue no downstream request. Writes to them are accepted and leave the base register unchanged. Reads of them return zero with `up_rvalid` one cycle after acceptance.
- R6: Downstream read data and its valid strobe appear on `up_rdata`/`up_rvalid` in the same cycle.
- R7: A local read (address 4096 or above) sees `up_ardy` low while any forwarded read is outstanding. It is accepted in the first cycle after the last outstanding read data has returned.
- R8: With MAX_OUT (default 8) forwarded reads outstanding, a window read sees `up_ardy` and `dn_rd` low until a read response returns.
- R9: The downstream address is the full 33-bit sum of the zero-extended base register and upstream address, including the carry into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_addr | input | 32 | Upstream byte address |
| up_rd | input | 1 | Upstream read request |
| up_wr | input | 1 | Upstream write request |
| up_ardy | output | 1 | Upstream request accepted this cycle |
| up_be | input | 4 | Upstream write byte enables |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Upstream read data |
| up_rvalid | output | 1 | Upstream read data valid |
| dn_addr | output | 33 | Downstream byte address |
| dn_rd | output | 1 | Downstream read request |
| dn_wr | output | 1 | Downstream write request |
| dn_ardy | input | 1 | Downstream request accepted |
| dn_be | output | 4 | Downstream write byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| dn_rvalid | input | 1 | Downstream read data valid |

## Verification
Forwarded requests, `up_ardy` and downstream read responses are combinational. The bench checks them half a cycle after driving the inputs, in the same cycle. Local read data comes from a single register stage and is due on the cycle after the accepting edge. A base write is checked through a later register read, never in its own cycle. For the ordering and limit cases, the bench counts accepting edges one by one. It checks `up_ardy` on each side of the edge that retires the last outstanding read.

// File: rtl/addr_window_pkg.sv
package addr_window_pkg;

    localparam int UP_AW   = 32;
    localparam int DN_AW   = 33;
    localparam int DW      = 32;
    localparam int BEW     = DW / 8;
    localparam int WIN_LEN = 4096;

    typedef enum logic [1:0] {
        RGN_WIN  = 2'd0,
        RGN_BASE = 2'd1,
        RGN_VOID = 2'd2
    } region_e;

    typedef struct packed {
        logic            valid;
        logic [DW-1:0]   data;
    } local_rsp_t;

    function automatic region_e classify(input logic [UP_AW-1:0] a,
                                         input logic [UP_AW-1:0] win_len);
        if (a < win_len)       return RGN_WIN;
        else if (a == win_len) return RGN_BASE;
        else                   return RGN_VOID;
    endfunction

endpackage

// File: rtl/awb_base_reg.sv
module awb_base_reg
    import addr_window_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     base
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                base[8*g +: 8] <= '0;
            else if (wr_en && be[g])
                base[8*g +: 8] <= wdata[8*g +: 8];
        end
    end

    // R1
    base_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> base == '0);

    // R3
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(base));
endmodule

// File: rtl/awb_rd_tracker.sv
module awb_rd_tracker #(
    parameter int MAX_OUT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic retire,
    output logic idle,
    output logic full
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (issue && !retire)
            cnt <= cnt + CNT_W'(1);
        else if (!issue && retire && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign idle = (cnt == '0);
    assign full = (cnt == CNT_W'(MAX_OUT));

    // R8
    cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_OUT));

    // R8
    no_issue_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !issue);
endmodule

// File: rtl/addr_window_bridge.sv
module addr_window_bridge
    import addr_window_pkg::*;
#(
    parameter int MAX_OUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UP_AW-1:0]  up_addr,
    input  logic              up_rd,
    input  logic              up_wr,
    output logic              up_ardy,
    input  logic [BEW-1:0]    up_be,
    input  logic [DW-1:0]     up_wdata,
    output logic [DW-1:0]     up_rdata,
    output logic              up_rvalid,
    output logic [DN_AW-1:0]  dn_addr,
    output logic              dn_rd,
    output logic              dn_wr,
    input  logic              dn_ardy,
    output logic [BEW-1:0]    dn_be,
    output logic [DW-1:0]     dn_wdata,
    input  logic [DW-1:0]     dn_rdata,
    input  logic              dn_rvalid
);
    localparam logic [UP_AW-1:0] WIN_END = UP_AW'(WIN_LEN);

    region_e     rgn;
    logic        in_win;
    logic [DW-1:0] base;
    logic        rd_idle;
    logic        rd_full;
    logic        fwd_rd_acc;
    logic        loc_rd_acc;
    logic        base_wr;
    local_rsp_t  rsp_q;

    assign rgn    = classify(up_addr, WIN_END);
    assign in_win = (rgn == RGN_WIN);

    // forwarding path
    assign dn_addr  = DN_AW'(base) + DN_AW'(up_addr);
    assign dn_rd    = up_rd && in_win && !rd_full;
    assign dn_wr    = up_wr && in_win;
    assign dn_be    = up_be;
    assign dn_wdata = up_wdata;

    always_comb begin
        if (in_win)
            up_ardy = dn_ardy && !(up_rd && rd_full);
        else if (up_rd)
            up_ardy = rd_idle;
        else
            up_ardy = 1'b1;
    end

    assign fwd_rd_acc = dn_rd && dn_ardy;
    assign loc_rd_acc = up_rd && !in_win && rd_idle;
    assign base_wr    = up_wr && (rgn == RGN_BASE);

    awb_base_reg #(.DATA_W(DW)) u_base (
        .clk   (clk),
        .rst   (rst),
        .wr_en (base_wr),
        .be    (up_be),
        .wdata (up_wdata),
        .base  (base)
    );

    awb_rd_tracker #(.MAX_OUT(MAX_OUT)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .issue  (fwd_rd_acc),
        .retire (dn_rvalid),
        .idle   (rd_idle),
        .full   (rd_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= loc_rd_acc;
            rsp_q.data  <= (rgn == RGN_BASE) ? base : '0;
        end
    end

    assign up_rvalid = rsp_q.valid || dn_rvalid;
    assign up_rdata  = rsp_q.valid ? rsp_q.data : dn_rdata;

    // R4
    local_rsp_due_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rd && up_ardy && !in_win) |=> up_rvalid);

    // R7
    rsp_collide_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_q.valid && dn_rvalid));

    // R2
    dn_only_win_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_rd || dn_wr) |-> (up_addr < WIN_END));

    // R5
    void_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (up_wr && rgn == RGN_VOID) |=> $stable(base));

    // R3
    base_full_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (up_wr && up_ardy && rgn == RGN_BASE && up_be == '1)
            |=> base == $past(up_wdata));
endmodule

// File: tb/sim_addr_window_bridge.sv
module sim_addr_window_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] up_addr;
    logic        up_rd, up_wr, up_ardy, up_rvalid;
    logic [3:0]  up_be;
    logic [31:0] up_wdata, up_rdata;
    logic [32:0] dn_addr;
    logic        dn_rd, dn_wr, dn_ardy, dn_rvalid;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata, dn_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    addr_window_bridge u0 (.*);

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] addr;
        logic [32:0] exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_0000, 32'h0000_0010, 33'h0_0000_0010},
        '{32'h0000_1000, 32'h0000_0FFF, 33'h0_0000_1FFF},
        '{32'hFFFF_F800, 32'h0000_0900, 33'h1_0000_0100},
        '{32'hFFFF_FFFF, 32'h0000_0FFF, 33'h1_0000_0FFE}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        up_addr = '0; up_rd = 0; up_wr = 0; up_be = '0; up_wdata = '0;
        dn_ardy = 0; dn_rvalid = 0; dn_rdata = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        up_addr = a; up_wr = 1; up_be = be; up_wdata = d;
        @(negedge clk);
        chk("R3 wr ardy", 64'(up_ardy), 64'd1);
        chk("R3 no dn req", 64'(dn_wr | dn_rd), 64'd0);
        step();
        up_wr = 0;
    endtask

    task automatic reg_read(input logic [31:0] a, input logic [31:0] exp, input string req);
        up_addr = a; up_rd = 1;
        @(negedge clk);
        chk({req, " rd ardy"}, 64'(up_ardy), 64'd1);
        chk({req, " no dn rd"}, 64'(dn_rd), 64'd0);
        step();
        up_rd = 0;
        @(negedge clk);
        chk({req, " rvalid"}, 64'(up_rvalid), 64'd1);
        chk({req, " rdata"}, 64'(up_rdata), 64'(exp));
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 rvalid low", 64'(up_rvalid), 64'd0);
        step();
        reg_read(32'd4096, 32'h0, "R1");

        // table walk: R2, R9
        foreach (VECS[i]) begin
            reg_write(32'd4096, VECS[i].base, 4'hF);
            up_addr = VECS[i].addr; up_wr = 1; up_be = 4'h6;
            up_wdata = 32'h5A5A_0000 + 32'(i); dn_ardy = 1;
            @(negedge clk);
            chk("R9 dn_addr", 64'(dn_addr), 64'(VECS[i].exp));
            chk("R2 dn_wr", 64'(dn_wr), 64'd1);
            chk("R2 dn_be", 64'(dn_be), 64'h6);
            chk("R2 dn_wdata", 64'(dn_wdata), 64'(32'h5A5A_0000 + 32'(i)));
            chk("R2 ardy follows", 64'(up_ardy), 64'd1);
            dn_ardy = 0;
            #0.5;
            chk("R2 ardy stall", 64'(up_ardy), 64'd0);
            step();
            up_wr = 0;
        end

        // R3 byte lanes
        reg_write(32'd4096, 32'h1122_3344, 4'hF);
        reg_write(32'd4096, 32'hAABB_CCDD, 4'b0101);
        reg_read(32'd4096, 32'h11BB_33DD, "R3 lanes");
        reg_read(32'd4096, 32'h11BB_33DD, "R4");

        // R5 void region
        reg_write(32'h0000_2000, 32'hFFFF_FFFF, 4'hF);
        reg_write(32'd4097, 32'h0, 4'hF);
        reg_read(32'd4096, 32'h11BB_33DD, "R5 base kept");
        reg_read(32'h0000_2000, 32'h0, "R5 void read");

        // R6, R7 ordering
        up_addr = 32'h40; up_rd = 1; dn_ardy = 1;
        @(negedge clk);
        chk("R2 dn_rd", 64'(dn_rd), 64'd1);
        step();
        up_addr = 32'd4096;
        @(negedge clk);
        chk("R7 held", 64'(up_ardy), 64'd0);
        chk("R7 no dn rd", 64'(dn_rd), 64'd0);
        step();
        dn_rvalid = 1; dn_rdata = 32'hCAFE_0001;
        @(negedge clk);
        chk("R6 rvalid", 64'(up_rvalid), 64'd1);
        chk("R6 rdata", 64'(up_rdata), 64'hCAFE_0001);
        chk("R7 still held", 64'(up_ardy), 64'd0);
        step();
        dn_rvalid = 0;
        @(negedge clk);
        chk("R7 released", 64'(up_ardy), 64'd1);
        step();
        up_rd = 0;
        @(negedge clk);
        chk("R7 local rvalid", 64'(up_rvalid), 64'd1);
        chk("R7 local rdata", 64'(up_rdata), 64'h11BB_33DD);
        step();

        // R8 limit
        up_addr = 32'h80; up_rd = 1; dn_ardy = 1;
        for (int k = 0; k < 8; k++) step();
        @(negedge clk);
        chk("R8 ardy low at limit", 64'(up_ardy), 64'd0);
        chk("R8 dn_rd low at limit", 64'(dn_rd), 64'd0);
        step();
        up_rd = 0; dn_rvalid = 1; dn_rdata = 32'h0BAD_F00D;
        for (int k = 0; k < 8; k++) step();
        dn_rvalid = 0;
        up_addr = 32'd4096; up_rd = 1;
        @(negedge clk);
        chk("R8 drained", 64'(up_ardy), 64'd1);
        step();
        up_rd = 0;
        step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule